// File: doc/BRIEF.md
# Eight-Channel Capture/Compare Timer with Overflow Flag

The block is a 16-bit free-running counter shared by eight channels and reached through a byte-wide register bus. Each channel holds one 16-bit register. A mode bit gives that register one of two jobs. In capture mode it records the counter value when a selected edge arrives on the channel input. In compare mode it is a target value: when the counter steps onto that value, the channel flags the event and toggles its output pin. A parameter mask declares which channels exist. An absent channel reads as zero and ignores writes.

The counter advances once per `tick` pulse while the run bit is set, and holds otherwise. When it wraps from 0xFFFF to 0x0000 it raises an overflow flag. Software clears that flag by writing a one to bit 7, which works only while the run bit or the alternate-enable bit is set. In fast-clear mode, any bus touch of the counter address pair clears the flag.

A bus cycle is one clock with `busSel` high. A write takes effect at that edge. Read data is combinational from the address, and any side effect of a read happens at the edge. 16-bit values move as two bytes, high byte first. Reading a high byte freezes the matching low byte in a shared holding register. Writing a high byte only stages it, and writing the low byte commits both bytes.

Register map (6-bit address): 0x00 control (bit 7 run, bit 6 alternate enable, bit 5 fast clear); 0x01 channel modes (bit n = channel n, 1 = compare); 0x02 edge selects for channels 0–3, 0x03 for channels 4–7 (channel n uses bits 2(n mod 4)+1 : 2(n mod 4)); 0x04 channel flags; 0x05 overflow flag at bit 7; 0x06/0x07 counter high/low; 0x10+2n / 0x11+2n channel n high/low.

Top module: `tmr_capcmp_top`

## Requirements
- R1: After reset the counter is 0. It increments by one (modulo 2^16) at each clock edge where the run bit (0x00 bit 7) and `tick` are both high, and holds otherwise. It reads at 0x06 (high) and 0x07 (low).
- R2: Reset clears every channel register, the control, mode and edge registers, all channel flags, `cmpOut` and the overflow flag.
- R3: A write to a channel register whose mode bit is 0 (capture) leaves it unchanged. Reads work in either mode.
- R4: In capture mode, the 2-bit edge select (00 none, 01 rising, 10 falling, 11 both) picks which edge of the input is acted on, after a two-flop synchronizer. On a selected edge the register loads the current counter value and the channel flag sets.
- R5: In compare mode (mode bit 1), when the counter advances onto the register value, the channel flag sets and that channel's `cmpOut` bit toggles.
- R6: Channel n's high byte is at 0x10+2n and its low byte at 0x11+2n.
- R7: Reading a high byte (channel or counter) stores its low byte. A later low-byte read returns that stored byte. Writing a high byte only stages it. Writing the low byte commits {staged, written} to the channel.
- R8: A channel cleared in `PRESENT_MASK` reads as zero, ignores writes, and never flags or toggles.
- R9: The overflow flag (port `ovfFlag`, 0x05 bit 7) sets when the counter advances from 0xFFFF to 0x0000.
- R10: Writing 1 to 0x05 bit 7 clears the overflow flag only while the run bit or the alternate-enable bit (0x00 bit 6) is set. Otherwise the flag is kept.
- R11: With fast clear (0x00 bit 5) set, any read or write of 0x06 or 0x07 clears the overflow flag. With it clear, such accesses leave the flag alone.
- R12: Writing 1 to bit n of 0x04 clears channel flag n. Bits written 0 are untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Counter clock enable |
| busSel | input | 1 | Bus access this cycle |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | 6 | Byte address |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data (combinational) |
| capIn | input | 8 | Asynchronous capture inputs, one per channel |
| cmpOut | output | 8 | Compare outputs, toggled on match |
| chFlag | output | 8 | Per-channel event flags |
| ovfFlag | output | 1 | Counter overflow flag |

## Verification
The bench builds the block with `PRESENT_MASK = 8'h7F`, so channel 7 is absent while channels 0–6 are live. A single run therefore covers the zero-read and write-ignore path next to a full sweep of the present channels. It tracks the counter arithmetically from the exact number of enabled ticks. That lets it predict compare hits as a window (start, start+n] and captured values exactly. Two full counter wraps fit in the run, which puts the overflow set, the gated clear and the fast clear within reach.

// File: rtl/tcc_pkg.sv
package tcc_pkg;
  localparam int CH_N   = 8;
  localparam int CNT_W  = 16;
  localparam int ADDR_W = 6;
  localparam int DATA_W = 8;
  localparam int IDX_W  = $clog2(CH_N);

  // configuration and one-cycle strobes from control to datapath
  typedef struct packed {
    logic              tmrEn;
    logic              paccEn;
    logic              fastClr;
    logic [CH_N-1:0]   chMode;
    logic [2*CH_N-1:0] edgeSel;
    logic              ovfClr;
    logic              cntTouch;
    logic [CH_N-1:0]   flagClr;
    logic [CH_N-1:0]   chCommit;
    logic [CNT_W-1:0]  commitData;
  } tccStb_t;
endpackage

// File: rtl/tcc_channel.sv
module tcc_channel
  import tcc_pkg::*;
#(
  parameter bit PRESENT = 1'b1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             capSync,
  input  logic             mode,
  input  logic [1:0]       edgeSel,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] cntNext,
  input  logic             advance,
  input  logic             commit,
  input  logic [CNT_W-1:0] commitData,
  input  logic             flagClr,
  output logic [CNT_W-1:0] value,
  output logic             flag,
  output logic             toggleOut
);
  logic prevIn;
  logic rise, fall, capHit, cmpHit;

  assign rise = capSync & ~prevIn;
  assign fall = ~capSync & prevIn;

  always_comb begin
    capHit = 1'b0;
    if (PRESENT && !mode) begin
      unique case (edgeSel)
        2'b01:   capHit = rise;
        2'b10:   capHit = fall;
        2'b11:   capHit = rise | fall;
        default: capHit = 1'b0;
      endcase
    end
  end

  assign cmpHit = PRESENT && mode && advance && (cntNext == value);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevIn    <= 1'b0;
      value     <= '0;
      flag      <= 1'b0;
      toggleOut <= 1'b0;
    end else if (!PRESENT) begin
      prevIn    <= 1'b0;
      value     <= '0;
      flag      <= 1'b0;
      toggleOut <= 1'b0;
    end else begin
      prevIn <= capSync;
      if (capHit)
        value <= cnt;
      else if (commit && mode)
        value <= commitData;
      if (capHit || cmpHit)
        flag <= 1'b1;
      else if (flagClr)
        flag <= 1'b0;
      if (cmpHit)
        toggleOut <= ~toggleOut;
    end
  end
endmodule

// File: rtl/tcc_datapath.sv
module tcc_datapath
  import tcc_pkg::*;
#(
  parameter logic [CH_N-1:0] PRESENT_MASK = '1
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       tick,
  input  logic [CH_N-1:0]            capIn,
  input  tccStb_t                    stb,
  output logic [CNT_W-1:0]           cnt,
  output logic [CH_N-1:0][CNT_W-1:0] chanReg,
  output logic [CH_N-1:0]            chFlag,
  output logic [CH_N-1:0]            cmpOut,
  output logic                       ovfFlag
);
  logic             advance, wrap;
  logic [CNT_W-1:0] cntNext;
  logic [CH_N-1:0]  syncA, syncB;

  assign advance = stb.tmrEn & tick;
  assign cntNext = cnt + 1'b1;
  assign wrap    = advance && (cnt == {CNT_W{1'b1}});

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt     <= '0;
      ovfFlag <= 1'b0;
      syncA   <= '0;
      syncB   <= '0;
    end else begin
      syncA <= capIn;
      syncB <= syncA;
      if (advance)
        cnt <= cntNext;
      if (wrap)
        ovfFlag <= 1'b1;
      else if (stb.ovfClr || stb.cntTouch)
        ovfFlag <= 1'b0;
    end
  end

  for (genvar g = 0; g < CH_N; g++) begin : g_ch
    tcc_channel #(.PRESENT(PRESENT_MASK[g])) u_ch (
      .clk       (clk),
      .rstN      (rstN),
      .capSync   (syncB[g]),
      .mode      (stb.chMode[g]),
      .edgeSel   (stb.edgeSel[2*g +: 2]),
      .cnt       (cnt),
      .cntNext   (cntNext),
      .advance   (advance),
      .commit    (stb.chCommit[g]),
      .commitData(stb.commitData),
      .flagClr   (stb.flagClr[g]),
      .value     (chanReg[g]),
      .flag      (chFlag[g]),
      .toggleOut (cmpOut[g])
    );
  end
endmodule

// File: rtl/tcc_ctrl.sv
module tcc_ctrl
  import tcc_pkg::*;
(
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       busSel,
  input  logic                       busWr,
  input  logic [ADDR_W-1:0]          busAddr,
  input  logic [DATA_W-1:0]          busWdata,
  output logic [DATA_W-1:0]          busRdata,
  input  logic [CNT_W-1:0]           cnt,
  input  logic [CH_N-1:0][CNT_W-1:0] chanReg,
  input  logic [CH_N-1:0]            chFlag,
  input  logic                       ovfFlag,
  output tccStb_t                    stb
);
  localparam logic [ADDR_W-1:0] A_CTL  = 6'h00;
  localparam logic [ADDR_W-1:0] A_MODE = 6'h01;
  localparam logic [ADDR_W-1:0] A_EDL  = 6'h02;
  localparam logic [ADDR_W-1:0] A_EDH  = 6'h03;
  localparam logic [ADDR_W-1:0] A_FLG  = 6'h04;
  localparam logic [ADDR_W-1:0] A_OVF  = 6'h05;
  localparam logic [ADDR_W-1:0] A_CNTH = 6'h06;
  localparam logic [ADDR_W-1:0] A_CNTL = 6'h07;

  logic              tmrEn, paccEn, fastClr;
  logic [CH_N-1:0]   chMode;
  logic [2*CH_N-1:0] edgeSel;
  logic [DATA_W-1:0] wrStage, rdLatch;
  logic              wrAcc, rdAcc, isChan, isCnt, isHi;
  logic [IDX_W-1:0]  chIdx;

  assign wrAcc  = busSel & busWr;
  assign rdAcc  = busSel & ~busWr;
  assign isChan = (busAddr[ADDR_W-1:4] == 2'b01);
  assign isCnt  = (busAddr == A_CNTH) || (busAddr == A_CNTL);
  assign isHi   = ~busAddr[0];
  assign chIdx  = busAddr[IDX_W:1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tmrEn   <= 1'b0;
      paccEn  <= 1'b0;
      fastClr <= 1'b0;
      chMode  <= '0;
      edgeSel <= '0;
      wrStage <= '0;
      rdLatch <= '0;
    end else begin
      if (wrAcc) begin
        unique case (busAddr)
          A_CTL:   {tmrEn, paccEn, fastClr} <= busWdata[7:5];
          A_MODE:  chMode <= busWdata;
          A_EDL:   edgeSel[DATA_W-1:0] <= busWdata;
          A_EDH:   edgeSel[2*CH_N-1:DATA_W] <= busWdata;
          default: if (isChan && isHi) wrStage <= busWdata;
        endcase
      end
      if (rdAcc && isChan && isHi)
        rdLatch <= chanReg[chIdx][DATA_W-1:0];
      else if (rdAcc && busAddr == A_CNTH)
        rdLatch <= cnt[DATA_W-1:0];
    end
  end

  always_comb begin
    unique case (busAddr)
      A_CTL:   busRdata = {tmrEn, paccEn, fastClr, 5'b0};
      A_MODE:  busRdata = chMode;
      A_EDL:   busRdata = edgeSel[DATA_W-1:0];
      A_EDH:   busRdata = edgeSel[2*CH_N-1:DATA_W];
      A_FLG:   busRdata = chFlag;
      A_OVF:   busRdata = {ovfFlag, 7'b0};
      A_CNTH:  busRdata = cnt[CNT_W-1:DATA_W];
      A_CNTL:  busRdata = rdLatch;
      default: begin
        if (isChan)
          busRdata = isHi ? chanReg[chIdx][CNT_W-1:DATA_W] : rdLatch;
        else
          busRdata = '0;
      end
    endcase
  end

  always_comb begin
    stb            = '0;
    stb.tmrEn      = tmrEn;
    stb.paccEn     = paccEn;
    stb.fastClr    = fastClr;
    stb.chMode     = chMode;
    stb.edgeSel    = edgeSel;
    stb.ovfClr     = wrAcc && (busAddr == A_OVF) && busWdata[7] && (tmrEn || paccEn);
    stb.cntTouch   = busSel && isCnt && fastClr;
    stb.flagClr    = (wrAcc && busAddr == A_FLG) ? busWdata : '0;
    stb.commitData = {wrStage, busWdata};
    if (wrAcc && isChan && !isHi)
      stb.chCommit[chIdx] = 1'b1;
  end
endmodule

// File: rtl/tmr_capcmp_top.sv
module tmr_capcmp_top
  import tcc_pkg::*;
#(
  parameter logic [CH_N-1:0] PRESENT_MASK = '1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic [CH_N-1:0]   capIn,
  output logic [CH_N-1:0]   cmpOut,
  output logic [CH_N-1:0]   chFlag,
  output logic              ovfFlag
);
  tccStb_t                    stb;
  logic [CNT_W-1:0]           cnt;
  logic [CH_N-1:0][CNT_W-1:0] chanReg;

  tcc_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .busSel  (busSel),
    .busWr   (busWr),
    .busAddr (busAddr),
    .busWdata(busWdata),
    .busRdata(busRdata),
    .cnt     (cnt),
    .chanReg (chanReg),
    .chFlag  (chFlag),
    .ovfFlag (ovfFlag),
    .stb     (stb)
  );

  tcc_datapath #(.PRESENT_MASK(PRESENT_MASK)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .tick   (tick),
    .capIn  (capIn),
    .stb    (stb),
    .cnt    (cnt),
    .chanReg(chanReg),
    .chFlag (chFlag),
    .cmpOut (cmpOut),
    .ovfFlag(ovfFlag)
  );
endmodule

// File: rtl/tcc_checker.sv
module tcc_checker
  import tcc_pkg::*;
(
  input logic                       clk,
  input logic                       rstN,
  input logic                       tick,
  input tccStb_t                    stb,
  input logic [CNT_W-1:0]           cnt,
  input logic [CH_N-1:0][CNT_W-1:0] chanReg,
  input logic                       ovfFlag
);
  p_cnt_hold_r1: assert property (@(posedge clk) disable iff (!rstN)
    !stb.tmrEn |=> $stable(cnt));

  p_cnt_step_r1: assert property (@(posedge clk) disable iff (!rstN)
    (stb.tmrEn && tick) |=> (cnt == $past(cnt) + 16'd1));

  p_ovf_wrap_r9: assert property (@(posedge clk) disable iff (!rstN)
    (stb.tmrEn && tick && cnt == 16'hFFFF) |=> ovfFlag);

  p_ovf_keep_r10: assert property (@(posedge clk) disable iff (!rstN)
    (ovfFlag && !stb.tmrEn && !stb.paccEn && !stb.cntTouch) |=> ovfFlag);

  p_fast_clr_r11: assert property (@(posedge clk) disable iff (!rstN)
    (stb.cntTouch && !(stb.tmrEn && tick && cnt == 16'hFFFF)) |=> !ovfFlag);

  for (genvar i = 0; i < CH_N; i++) begin : g_chk
    // R3: a capture channel with no edge selected never changes its register
    p_cap_frozen_r3: assert property (@(posedge clk) disable iff (!rstN)
      (!stb.chMode[i] && stb.edgeSel[2*i +: 2] == 2'b00) |=> $stable(chanReg[i]));
  end
endmodule

bind tmr_capcmp_top tcc_checker u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .tick   (tick),
  .stb    (stb),
  .cnt    (cnt),
  .chanReg(chanReg),
  .ovfFlag(ovfFlag)
);

// File: tb/sim_tmr_capcmp_top.sv
module sim_tmr_capcmp_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] MASK = 8'h7F;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tick = 1'b1;
  logic       busSel = 1'b0, busWr = 1'b0;
  logic [5:0] busAddr = '0;
  logic [7:0] busWdata = '0;
  logic [7:0] busRdata;
  logic [7:0] capIn = '0;
  logic [7:0] cmpOut, chFlag;
  logic       ovfFlag;

  int nChk = 0, nBad = 0;
  logic [15:0] expCnt = '0;
  logic [15:0] expReg [8];
  logic [7:0]  ctlBase = '0;
  logic [15:0] v16;
  logic [7:0]  v8;
  logic [15:0] c0;

  tmr_capcmp_top #(.PRESENT_MASK(MASK)) u0 (
    .clk(clk), .rstN(rstN), .tick(tick), .busSel(busSel), .busWr(busWr),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .capIn(capIn), .cmpOut(cmpOut), .chFlag(chFlag), .ovfFlag(ovfFlag)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic [5:0] a, input logic [7:0] d);
    busSel = 1'b1; busWr = 1'b1; busAddr = a; busWdata = d;
    @(posedge clk); #1;
    busSel = 1'b0; busWr = 1'b0;
  endtask

  task automatic busRead(input logic [5:0] a, output logic [7:0] d);
    busSel = 1'b1; busWr = 1'b0; busAddr = a;
    #1 d = busRdata;
    @(posedge clk); #1;
    busSel = 1'b0;
  endtask

  task automatic read16(input logic [5:0] hiAddr, output logic [15:0] v);
    logic [7:0] h, l;
    busRead(hiAddr, h);
    busRead(hiAddr + 6'd1, l);
    v = {h, l};
  endtask

  task automatic write16(input int ch, input logic [15:0] v);
    busWrite(6'(16 + 2*ch), v[15:8]);
    busWrite(6'(17 + 2*ch), v[7:0]);
  endtask

  // n enabled ticks: enable edge plus n-1 idle edges plus disable edge
  task automatic runTimer(input int n);
    busWrite(6'h00, ctlBase | 8'h80);
    repeat (n - 1) @(posedge clk);
    #1;
    busWrite(6'h00, ctlBase);
    if (tick) expCnt = 16'(expCnt + n);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nChk++; nBad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(posedge clk); #1;

    // R2 reset state
    for (int ch = 0; ch < 8; ch++) begin
      read16(6'(16 + 2*ch), v16);
      chk("R2 channel reset", v16, 16'h0000);
    end
    chk("R2 flags", chFlag, 8'h00);
    chk("R2 cmpOut", cmpOut, 8'h00);
    chk("R2 ovf", ovfFlag, 1'b0);
    busRead(6'h00, v8); chk("R2 control", v8, 8'h00);
    read16(6'h06, v16); chk("R1 counter reset", v16, 16'h0000);

    // R1 tick gating, then counting
    tick = 1'b0; runTimer(6); tick = 1'b1;
    read16(6'h06, v16); chk("R1 hold without tick", v16, 16'h0000);
    runTimer(37);
    read16(6'h06, v16); chk("R1 count", v16, expCnt);

    // R6 / R8 address sweep in compare mode
    busWrite(6'h01, 8'hFF);
    for (int ch = 0; ch < 8; ch++) begin
      expReg[ch] = MASK[ch] ? 16'(16'h1111 * (ch + 1)) : 16'h0000;
      write16(ch, 16'(16'h1111 * (ch + 1)));
    end
    for (int ch = 0; ch < 8; ch++) begin
      read16(6'(16 + 2*ch), v16);
      chk(ch == 7 ? "R8 absent channel" : "R6 channel map", v16, expReg[ch]);
    end

    // R3 capture-mode write ignored
    busWrite(6'h01, 8'hFE);
    write16(0, 16'hBEEF);
    read16(6'h10, v16); chk("R3 capture write ignored", v16, expReg[0]);

    // R5 compare sweep
    busWrite(6'h01, 8'hFF);
    c0 = expCnt;
    for (int ch = 0; ch < 7; ch++) begin
      expReg[ch] = 16'(c0 + 3*ch + 2);
      write16(ch, expReg[ch]);
    end
    busWrite(6'h04, 8'hFF);
    chk("R12 flags cleared", chFlag, 8'h00);
    runTimer(12);
    chk("R5 flags after 12", chFlag, 8'h0F);
    chk("R5 toggles after 12", cmpOut, 8'h0F);
    runTimer(20);
    chk("R5 flags after 32", chFlag, 8'h7F);
    chk("R5 toggles after 32", cmpOut, 8'h7F);
    busWrite(6'h04, 8'h0F);
    chk("R12 partial clear", chFlag, 8'h70);
    busWrite(6'h04, 8'hFF);
    chk("R12 full clear", chFlag, 8'h00);

    // R7 byte coherence on channel 3
    write16(3, 16'h1234);
    busRead(6'h16, v8); chk("R7 high byte", v8, 8'h12);
    write16(3, 16'hABCD);
    busRead(6'h17, v8); chk("R7 latched low", v8, 8'h34);
    read16(6'h16, v16); chk("R7 committed", v16, 16'hABCD);
    busWrite(6'h16, 8'h77);
    read16(6'h16, v16); chk("R7 staged only", v16, 16'hABCD);
    expReg[3] = 16'hABCD;

    // R4 capture edges: ch0 rise, ch1 fall, ch2 both, ch3 none
    busWrite(6'h01, 8'hF0);
    busWrite(6'h02, 8'h39);
    busWrite(6'h04, 8'hFF);
    runTimer(5);
    capIn = 8'h0F;
    repeat (4) @(posedge clk); #1;
    read16(6'h10, v16); chk("R4 rise captured", v16, expCnt);
    read16(6'h12, v16); chk("R4 fall ignores rise", v16, expReg[1]);
    read16(6'h14, v16); chk("R4 both on rise", v16, expCnt);
    read16(6'h16, v16); chk("R4 none ignores", v16, expReg[3]);
    chk("R4 flags rise", chFlag & 8'h0F, 8'h05);
    expReg[0] = expCnt;
    busWrite(6'h04, 8'hFF);
    runTimer(7);
    capIn = 8'h00;
    repeat (4) @(posedge clk); #1;
    read16(6'h10, v16); chk("R4 rise ignores fall", v16, expReg[0]);
    read16(6'h12, v16); chk("R4 fall captured", v16, expCnt);
    read16(6'h14, v16); chk("R4 both on fall", v16, expCnt);
    read16(6'h16, v16); chk("R4 none ignores fall", v16, expReg[3]);
    chk("R4 flags fall", chFlag & 8'h0F, 8'h06);

    // R9 overflow, R10 gated clear, R11 fast clear
    ctlBase = 8'h00;
    runTimer(65536 - int'(expCnt));
    chk("R9 ovf port", ovfFlag, 1'b1);
    busRead(6'h05, v8); chk("R9 ovf reg", v8, 8'h80);
    read16(6'h06, v16); chk("R9 counter wrapped", v16, 16'h0000);
    chk("R11 no fast clear", ovfFlag, 1'b1);
    busWrite(6'h05, 8'h80);
    chk("R10 clear blocked", ovfFlag, 1'b1);
    busWrite(6'h00, 8'h40);
    busWrite(6'h05, 8'h80);
    chk("R10 clear with alt enable", ovfFlag, 1'b0);
    busWrite(6'h00, 8'h00);
    runTimer(65536);
    chk("R9 second wrap", ovfFlag, 1'b1);
    busWrite(6'h00, 8'h20);
    busRead(6'h06, v8);
    chk("R11 fast clear", ovfFlag, 1'b0);
    chk("R11 counter value", v8, 8'h00);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule